// File: doc/BRIEF.md
# Fan Motor PWM Duty Generator with Minimum-Duty Floor

This block produces the gate enables for one half-bridge leg of a fan motor driver. A free-running ramp counter is compared with a digital speed command and, when enabled, with a minimum-duty code. The larger of the two sets the share of each ramp period during which the high-side switch conducts. While the high side is off, the low side conducts as a synchronous rectifier. A one-clock dead gap separates every handover between the two sides, and they are never on together.

Protection inputs shape the high-side pulse. A peak-current flag during the conducting phase blanks the high side until the ramp wraps. A gate-supply-bad flag forces the high side off. A not-yet-settled flag stops the low side from rectifying. A global drive enable gates both outputs at once and leaves the ramp running. The block also drives a sensor-bias enable that drops when the command is very low, but only when no floor is configured.

Top module: `pwm_floor_gen`

## Requirements
- R1: While reset is held both gate enables are low. After reset the ramp counts 0 to 255 and wraps, so the pulse pattern repeats every 256 clocks.
- R2: With no floor and no protection active, the effective duty D is the command code. Over any 256-clock window in steady state the high side is on for D-1 clocks when 0<D<256.
- R3: A command below 8 gives D=0, so the high side stays off. A command of 248 or more gives D=256, so the high side is on for all 256 clocks and the low side for none.
- R4: When the floor flag is set, D is the larger of the command-derived duty and the floor code. A floor code of 0, or a cleared floor flag, adds no floor.
- R5: Over a 256-clock window the low side is on for 255-D clocks when 0<D<256, and for 256 clocks when D=0. The two enables are never high in the same clock, and one clock of dead time separates each handover.
- R6: An overcurrent flag seen while the high side is demanded turns the high side off for the rest of the ramp period. Full duty resumes in the next period. A flag seen during the off phase has no effect.
- R7: When the gate-supply-good flag is low, the high side is off from the next clock on, and the low side stays on for all 256 clocks.
- R8: When the settled flag is low, the low side never turns on. The high side then loses no clock to dead time and is on for D clocks.
- R9: Dropping the drive enable turns both gate enables off in the same clock. The ramp keeps counting, so the pulses return in the same phase after re-enable.
- R10: The sensor-bias enable is low only when the floor flag is clear and the command is below 32. Otherwise it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_code | input | 8 | Speed command code |
| floor_code | input | 8 | Minimum-duty code |
| floor_en | input | 1 | Minimum duty in use |
| oc_trip | input | 1 | Peak-current comparator flag |
| gate_ok | input | 1 | Gate supply adequate |
| osc_ok | input | 1 | Reset settled, rectification allowed |
| drive_en | input | 1 | Global drive enable |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| bias_en | output | 1 | Sensor-bias enable |

## Verification
The gate enables come from registers that sit one clock behind the ramp comparison. Duty results therefore only settle after a full ramp period. Each duty check first waits 300 clocks after changing the inputs and then counts enable clocks over exactly 256 falling-edge samples, which makes the count independent of phase.

The drive enable and the sensor-bias enable are combinational. They are sampled 1 ns after the input changes at a falling edge. The gate-supply and overcurrent cut-offs are registered, so they are sampled at the next falling edge. The phase check for R9 compares the clock indices of high-side rising edges before and after the disable.

// File: rtl/pwm_floor_gen.sv
module pwm_floor_gen #(
  parameter int RAMP_W  = 8,
  parameter int CMD_LO  = 8,
  parameter int CMD_HI  = 248,
  parameter int BIAS_TH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RAMP_W-1:0] cmd_code,
  input  logic [RAMP_W-1:0] floor_code,
  input  logic              floor_en,
  input  logic              oc_trip,
  input  logic              gate_ok,
  input  logic              osc_ok,
  input  logic              drive_en,
  output logic              hs_en,
  output logic              ls_en,
  output logic              bias_en
);
  localparam logic [RAMP_W-1:0] LO_C   = RAMP_W'(CMD_LO);
  localparam logic [RAMP_W-1:0] HI_C   = RAMP_W'(CMD_HI);
  localparam logic [RAMP_W-1:0] BIAS_C = RAMP_W'(BIAS_TH);

  logic [RAMP_W-1:0] ramp;
  logic oc_lat, hs_q, ls_q;
  logic wrap, cmd_on, floor_on, demand, hs_want, ls_want;

  assign wrap     = (ramp == '1);
  assign cmd_on   = (cmd_code >= HI_C) || ((cmd_code >= LO_C) && (ramp < cmd_code));
  assign floor_on = floor_en && (ramp < floor_code);
  assign demand   = cmd_on || floor_on;
  assign hs_want  = demand && !oc_lat && !oc_trip && gate_ok;
  assign ls_want  = !hs_want && osc_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp   <= '0;
      oc_lat <= 1'b0;
      hs_q   <= 1'b0;
      ls_q   <= 1'b0;
    end else begin
      ramp   <= ramp + 1'b1;
      oc_lat <= wrap ? 1'b0 : (oc_lat || (oc_trip && demand));
      hs_q   <= hs_want && !ls_q;
      ls_q   <= ls_want && !hs_q;
    end
  end

  assign hs_en   = hs_q && drive_en;
  assign ls_en   = ls_q && drive_en;
  assign bias_en = floor_en || (cmd_code >= BIAS_C);

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  // R5
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_q) |-> !$past(hs_q));

  // R6
  oc_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_lat |-> !hs_q);

  // R7
  gate_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_ok |=> !hs_q);

  // R8
  no_rect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_ok |=> !ls_q);
endmodule

// File: tb/sim_pwm_floor_gen.sv
module sim_pwm_floor_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cmd_code = '0, floor_code = '0;
  logic floor_en = 1'b0, oc_trip = 1'b0, gate_ok = 1'b1, osc_ok = 1'b1, drive_en = 1'b1;
  logic hs_en, ls_en, bias_en;
  int checks = 0, fails = 0, cyc = 0;
  int hs_cnt, ls_cnt;
  int t_rise;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_floor_gen u0 (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .floor_code(floor_code),
    .floor_en(floor_en), .oc_trip(oc_trip), .gate_ok(gate_ok), .osc_ok(osc_ok),
    .drive_en(drive_en), .hs_en(hs_en), .ls_en(ls_en), .bias_en(bias_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic count(input int n);
    int ovl = 0;
    hs_cnt = 0; ls_cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hs_cnt += int'(hs_en);
      ls_cnt += int'(ls_en);
      if (hs_en && ls_en) ovl++;
    end
    chk("R5 overlap", ovl, 0);
  endtask

  task automatic apply(input int c, input int f, input logic fe);
    @(negedge clk);
    cmd_code = 8'(c); floor_code = 8'(f); floor_en = fe;
    repeat (300) @(negedge clk);
  endtask

  task automatic wait_rise();
    logic prev;
    @(negedge clk);
    prev = hs_en;
    forever begin
      @(negedge clk);
      if (!prev && hs_en) break;
      prev = hs_en;
    end
    t_rise = cyc;
  endtask

  task automatic duty_case(input string tag, input int c, input int f, input logic fe,
                           input int exp_hs, input int exp_ls);
    apply(c, f, fe);
    count(256);
    chk({tag, " hs"}, hs_cnt, exp_hs);
    chk({tag, " ls"}, ls_cnt, exp_ls);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset hs", int'(hs_en), 0);
    chk("R1 reset ls", int'(ls_en), 0);
    rst_n = 1'b1;
  endtask

  task automatic test_period();
    int t0;
    apply(128, 0, 1'b0);
    wait_rise(); t0 = t_rise;
    wait_rise();
    chk("R1 period", t_rise - t0, 256);
  endtask

  task automatic test_oc();
    apply(200, 0, 1'b0);
    wait_rise();
    repeat (50) @(negedge clk);
    oc_trip = 1'b1;
    @(negedge clk);
    oc_trip = 1'b0;
    count(150);
    chk("R6 blanked rest of period", hs_cnt, 0);
    count(256);
    chk("R6 next period restored", hs_cnt, 199);
    apply(100, 0, 1'b0);
    wait_rise();
    repeat (150) @(negedge clk);
    oc_trip = 1'b1;
    @(negedge clk);
    oc_trip = 1'b0;
    count(256);
    chk("R6 off-phase flag ignored", hs_cnt, 99);
  endtask

  task automatic test_gate();
    apply(100, 0, 1'b0);
    wait_rise();
    gate_ok = 1'b0;
    @(negedge clk);
    chk("R7 hs cut next clock", int'(hs_en), 0);
    repeat (300) @(negedge clk);
    count(256);
    chk("R7 hs", hs_cnt, 0);
    chk("R7 ls", ls_cnt, 256);
    gate_ok = 1'b1;
  endtask

  task automatic test_osc();
    osc_ok = 1'b0;
    apply(100, 0, 1'b0);
    count(256);
    chk("R8 ls", ls_cnt, 0);
    chk("R8 hs", hs_cnt, 100);
    osc_ok = 1'b1;
  endtask

  task automatic test_drive();
    int t0;
    apply(128, 0, 1'b0);
    wait_rise(); t0 = t_rise;
    drive_en = 1'b0;
    #1;
    chk("R9 hs off same cycle", int'(hs_en), 0);
    count(300);
    chk("R9 hs during disable", hs_cnt, 0);
    chk("R9 ls during disable", ls_cnt, 0);
    drive_en = 1'b1;
    wait_rise();
    chk("R9 phase kept", (t_rise - t0) % 256, 0);
  endtask

  task automatic test_bias();
    @(negedge clk);
    floor_en = 1'b0; cmd_code = 8'd31; #1;
    chk("R10 low cmd no floor", int'(bias_en), 0);
    cmd_code = 8'd32; #1;
    chk("R10 threshold", int'(bias_en), 1);
    cmd_code = 8'd0; floor_en = 1'b1; floor_code = 8'd0; #1;
    chk("R10 floor keeps bias", int'(bias_en), 1);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    duty_case("R2 mid", 128, 0, 1'b0, 127, 127);
    duty_case("R2 low edge", 8, 0, 1'b0, 7, 247);
    duty_case("R2 high edge", 247, 0, 1'b0, 246, 8);
    duty_case("R3 below", 5, 0, 1'b0, 0, 256);
    duty_case("R3 at top", 248, 0, 1'b0, 256, 0);
    duty_case("R3 above", 250, 0, 1'b0, 256, 0);
    duty_case("R4 floor wins", 5, 60, 1'b1, 59, 195);
    duty_case("R4 cmd wins", 128, 60, 1'b1, 127, 127);
    duty_case("R4 floor zero", 5, 0, 1'b1, 0, 256);
    duty_case("R4 floor off", 5, 60, 1'b0, 0, 256);
    test_period();
    test_oc();
    test_gate();
    test_osc();
    test_drive();
    test_bias();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule